// File: doc/BRIEF.md
# Timer Input Capture Unit

This block timestamps events on an external capture input against a free-running timer. The capture input is brought into the clock domain through a short synchroniser chain. When the selected transition appears (rising or falling, chosen by a polarity input), the block copies the timer count into a capture register. The same event sets a sticky capture flag, which software later clears with a one-cycle clear strobe. An interrupt request is raised while the flag is set and the capture interrupt is enabled.

The counter can also be configured to use the capture register as its wrap (TOP) value. While that mode indication is asserted, the capture input is ignored. The register keeps whatever value the counter logic relies on, and the flag is never set by pin activity.

Top module: `tmr_capture_unit`

## Requirements
- R1: With `edge_sel` = 1, a 0-to-1 transition on `cap_pin` copies `cnt_val` into `cap_val` and sets `cap_flag`.
- R2: With `edge_sel` = 0, a 1-to-0 transition on `cap_pin` copies `cnt_val` into `cap_val` and sets `cap_flag`.
- R3: A transition of the polarity not selected by `edge_sel` changes neither `cap_val` nor `cap_flag`.
- R4: With the default two synchroniser stages, a pin change that is first sampled at clock edge k is captured at edge k+2. The stored value is the `cnt_val` present at edge k+2, and `cap_flag` is still 0 after edge k+1.
- R5: `cap_flag` stays set until a cycle with `flag_clr` = 1, and it reads 0 after that clock edge.
- R6: When a capture and `flag_clr` fall on the same clock edge, the capture wins and `cap_flag` stays 1.
- R7: `cap_irq` is 1 exactly when `cap_flag` = 1 and `irq_en` = 1, in the same cycle.
- R8: While `top_mode` = 1, pin transitions update neither `cap_val` nor `cap_flag`. A transition seen during that time also causes no capture after `top_mode` returns to 0.
- R9: Changing `edge_sel` while `cap_pin` is steady causes no capture.
- R10: Reset clears `cap_val` and `cap_flag` to 0. A pin that is already high when reset is released causes no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cap_pin | input | 1 | External capture input, asynchronous |
| cnt_val | input | CNT_W | Current timer count |
| edge_sel | input | 1 | 1 selects rising edges, 0 selects falling edges |
| irq_en | input | 1 | Capture interrupt enable |
| flag_clr | input | 1 | One-cycle strobe that clears the capture flag |
| top_mode | input | 1 | 1 while the capture register serves as the counter TOP value |
| cap_val | output | CNT_W | Capture register |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Capture interrupt request |

## Verification
The assertions check, on every cycle, the following relations:
- The interrupt request agrees with the flag and the enable.
- The capture register only moves when the flag ends up set.
- A set flag survives any cycle without a clear.
- The TOP mode freezes both the register and the flag.

Only the bench scenarios can show that the correct polarity is chosen and that the captured count comes from the right cycle of the synchroniser latency. The same holds for the capture-over-clear priority, the absence of false captures from polarity changes or reset release, and the fact that edges swallowed during TOP mode are not replayed afterwards.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic {
        CAP_EDGE_FALL = 1'b0,
        CAP_EDGE_RISE = 1'b1
    } cap_edge_e;

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic samp,
    output logic samp_vld
);
    // level shift chain plus a parallel chain marking samples taken after reset
    logic [STAGES-1:0] lvl_d, lvl_q;
    logic [STAGES-1:0] vld_d, vld_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                lvl_d = din;
                vld_d = 1'b1;
            end
        end else begin : g_chain
            always_comb begin
                lvl_d = {lvl_q[STAGES-2:0], din};
                vld_d = {vld_q[STAGES-2:0], 1'b1};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= '0;
            vld_q <= '0;
        end else begin
            lvl_q <= lvl_d;
            vld_q <= vld_d;
        end
    end

    assign samp     = lvl_q[STAGES-1];
    assign samp_vld = vld_q[STAGES-1];

endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      samp,
    input  logic      samp_vld,
    input  cap_edge_e pol,
    output logic      hit
);
    typedef struct packed {
        logic prev;
        logic prev_vld;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic     rise, fall, pair_ok;

    always_comb begin
        st_d.prev     = samp;
        st_d.prev_vld = samp_vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // only two consecutive valid samples can form an edge
    always_comb begin
        pair_ok = samp_vld && st_q.prev_vld;
        rise    = pair_ok && samp && !st_q.prev;
        fall    = pair_ok && !samp && st_q.prev;
        hit     = (pol == CAP_EDGE_RISE) ? rise : fall;
    end

endmodule

// File: rtl/tmr_capture_unit.sv
module tmr_capture_unit
    import cap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_pin,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             edge_sel,
    input  logic             irq_en,
    input  logic             flag_clr,
    input  logic             top_mode,
    output logic [CNT_W-1:0] cap_val,
    output logic             cap_flag,
    output logic             cap_irq
);
    typedef struct packed {
        logic [CNT_W-1:0] icr;
        logic             flag;
    } cap_st_t;

    cap_st_t   st_d, st_q;
    logic      pin_s, pin_s_vld, edge_hit, take;
    cap_edge_e pol;

    assign pol = cap_edge_e'(edge_sel);

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (cap_pin),
        .samp     (pin_s),
        .samp_vld (pin_s_vld)
    );

    cap_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp     (pin_s),
        .samp_vld (pin_s_vld),
        .pol      (pol),
        .hit      (edge_hit)
    );

    // edge history keeps tracking in TOP mode; only the update is blocked
    assign take = edge_hit && !top_mode;

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.icr  = cnt_val;
            st_d.flag = 1'b1;
        end else if (flag_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_val  = st_q.icr;
    assign cap_flag = st_q.flag;
    assign cap_irq  = st_q.flag && irq_en;

endmodule

// File: rtl/tmr_capture_unit_chk.sv
module tmr_capture_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_en,
    input logic             flag_clr,
    input logic             top_mode,
    input logic [CNT_W-1:0] cap_val,
    input logic             cap_flag,
    input logic             cap_irq
);
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |-> cap_flag);

    assert_irq_when_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && irq_en) |-> cap_irq);

    assert_value_moves_with_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_val) |-> cap_flag);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    assert_top_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        top_mode |=> ($stable(cap_val) && !$rose(cap_flag)));

    assert_clear_in_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && top_mode) |=> !cap_flag);

endmodule

bind tmr_capture_unit tmr_capture_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_en   (irq_en),
    .flag_clr (flag_clr),
    .top_mode (top_mode),
    .cap_val  (cap_val),
    .cap_flag (cap_flag),
    .cap_irq  (cap_irq)
);

// File: tb/sim_tmr_capture_unit.sv
module sim_tmr_capture_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic        sel = 1'b0;
    logic        ien = 1'b0;
    logic        clr = 1'b0;
    logic        top = 1'b0;
    logic [15:0] cnt;
    logic [15:0] val;
    logic        flag, irq;
    int          cyc = 0;
    int          nchk = 0;
    int          nerr = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign cnt = cyc[15:0];

    tmr_capture_unit u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(pin), .cnt_val(cnt),
        .edge_sel(sel), .irq_en(ien), .flag_clr(clr), .top_mode(top),
        .cap_val(val), .cap_flag(flag), .cap_irq(irq)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_flag();
        clr = 1'b1; tick(); clr = 1'b0; tick();
    endtask

    // one edge of direction d with polarity s, TOP mode t, enable e
    task automatic run_case(input bit s, input bit d, input bit t, input bit e);
        logic [15:0] base;
        int          e0;
        bit          cap;
        string       rq;
        pin = ~d; top = 1'b0;
        repeat (5) tick();
        sel = s; top = t; ien = e;
        clear_flag(); tick();
        chk("R5", "flag cleared before edge", flag, 0);
        base = val;
        e0 = cyc;
        pin = d;
        cap = !t && (d == s);
        rq = cap ? (s ? "R1" : "R2") : (t ? "R8" : "R3");
        tick(); tick();
        chk("R4", "flag one cycle early", flag, 0);
        tick();
        chk(rq, "cap_val", val, cap ? 32'(16'(e0 + 2)) : 32'(base));
        chk(rq, "cap_flag", flag, 32'(cap));
        chk("R7", "cap_irq", irq, 32'(cap && e));
        if (cap) begin
            repeat (3) tick();
            chk("R5", "flag sticky", flag, 1);
            clr = 1'b1; tick(); clr = 1'b0;
            chk("R5", "flag after clear", flag, 0);
            chk("R7", "irq after clear", irq, 0);
        end
        if (t) begin
            top = 1'b0;
            repeat (4) tick();
            chk("R8", "no replay flag", flag, 0);
            chk("R8", "no replay value", val, 32'(base));
        end
    endtask

    initial begin
        logic [15:0] keep;
        int          e0;
        pin = 1'b0;
        repeat (3) tick();
        chk("R10", "reset value", val, 0);
        chk("R10", "reset flag", flag, 0);
        rst_n = 1'b1;
        repeat (3) tick();

        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 2; d++)
                for (int t = 0; t < 2; t++)
                    for (int e = 0; e < 2; e++)
                        run_case(s[0], d[0], t[0], e[0]);

        // R6: capture and clear land on the same edge
        top = 1'b0; sel = 1'b1; ien = 1'b1; pin = 1'b0;
        repeat (5) tick();
        clear_flag();
        e0 = cyc; pin = 1'b1;
        tick(); tick();
        clr = 1'b1; tick(); clr = 1'b0;
        chk("R6", "capture beats clear flag", flag, 1);
        chk("R6", "capture beats clear value", val, 32'(16'(e0 + 2)));

        // R9: polarity toggling on a steady pin
        repeat (4) tick();
        clear_flag();
        keep = val;
        for (int i = 0; i < 6; i++) begin
            sel = ~sel; tick();
        end
        repeat (3) tick();
        chk("R9", "flag after polarity toggles", flag, 0);
        chk("R9", "value after polarity toggles", val, 32'(keep));

        // R10: pin high across reset release
        pin = 1'b1; sel = 1'b1;
        rst_n = 1'b0; repeat (2) tick();
        chk("R10", "value in reset", val, 0);
        rst_n = 1'b1; repeat (6) tick();
        chk("R10", "no capture at release flag", flag, 0);
        chk("R10", "no capture at release value", val, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule